// File: doc/BRIEF.md
# Multi-Board Collection Completion Monitor

This block sits on the processor side of a shared readout bus and follows one event at a time while several interface boards load their data. A start-load strobe opens an event. From then on the block watches each board's done flag and each word a board delivers, together with the event tag carried by that word. It pulses a completion signal once every enabled board has reported done. If something goes wrong first, it raises an error flag instead, records the cause and asks the system to resynchronise.

Three things count as an error. The first is a timeout: the done flags are not all set within a fixed number of clock cycles. The second is a word-count violation: one designated board must deliver exactly one word per event. The third is a tag mismatch: a word carries a tag that differs from the reference, which is the tag of the first word seen in the event. Boards cleared in the enable mask take no part in any of these checks. Each event ends with exactly one outcome, completion or error. The next start-load clears it.

Top module: `l2_collect_mon`

## Requirements
- R1: After reset, and in the cycle after any start-load, `collect_done`, `err_flag`, `resync_req` and `err_cause` are all zero. A start-load also begins a new event.
- R2: If no error has been found, `collect_done` is high for exactly one cycle, in the cycle after the first cycle in which every enabled board's done bit is high.
- R3: A board whose bit in `enable_mask` is 0 is ignored. Its done bit, its words and its tags have no effect. If the designated board is masked, no word-count check is made.
- R4: If the enabled done bits are not all high in any of the first TIMEOUT_CYC cycles after the start-load cycle, an error is raised. `err_cause` bit 0 is set, and the index field holds the lowest enabled board that is not done.
- R5: A second word from the enabled designated board (index SINGLE_IDX) within one event raises an error at once, with `err_cause` bit 1 set and the index field equal to SINGLE_IDX.
- R6: If all enabled boards are done but the enabled designated board has delivered no word, the block raises an error with `err_cause` bit 1 set instead of pulsing `collect_done`.
- R7: The reference tag is the tag of the first enabled word of the event. If several words arrive in that first cycle, the lowest board index gives the reference. Any enabled word whose tag differs raises an error with `err_cause` bit 2 set and the index field equal to the lowest mismatching board.
- R8: On an error, `err_flag` rises and holds until the next start-load. `resync_req` is high for exactly the one cycle in which `err_flag` rises.
- R9: Within one event, `collect_done` and `err_flag` are never both asserted. After the first outcome, no further outcome occurs until the next start-load.
- R10: When several causes occur in the same cycle, all of their bits are set. The index field follows the priority tag mismatch, then word count, then timeout.
- R11: `err_cause` bits 2:0 are the cause flags, and bits from 3 upward hold the board index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_load | input | 1 | Strobe that opens a new event |
| enable_mask | input | N_BOARDS | 1 = board takes part in the event |
| done_in | input | N_BOARDS | Per-board done flags |
| word_vld | input | N_BOARDS | Per-board word strobe |
| word_tag | input | N_BOARDS*TAG_W | Per-board event tag; board i occupies bits i*TAG_W upward |
| collect_done | output | 1 | One-cycle pulse: collection complete |
| err_flag | output | 1 | Error level, held until next start-load |
| err_cause | output | 3+IDX_W | {board index, tag, count, timeout} |
| resync_req | output | 1 | One-cycle request for a resynchronisation sequence |

## Verification
Some properties are checked by assertions on every cycle:
- the two outcomes never overlap;
- the resync request is a single pulse tied to the rise of the error flag;
- a start-load clears both outcomes;
- a raised error always carries a non-zero cause;
- the tag reference stays fixed once it is taken.

Other behaviour only the bench scenarios can show:
- the exact cycle of the timeout;
- which board index is reported;
- that masked boards are ignored;
- the choice of reference when words arrive in the same cycle;
- the index priority when causes coincide.

// File: rtl/clm_pkg.sv
// Shared definitions for the collection monitor.
// Assumes: the cause field layout below is decoded by software as is.
package clm_pkg;
    typedef enum logic [1:0] {PH_IDLE, PH_COLLECT, PH_CLOSED} phase_t;
    localparam int CAUSE_TIMEOUT = 0;
    localparam int CAUSE_COUNT   = 1;
    localparam int CAUSE_TAG     = 2;
    localparam int CAUSE_FLAGS   = 3;
endpackage

// File: rtl/clm_tag_check.sv
// Captures the event's reference tag and flags any enabled word whose tag differs.
// Assumes: vld is already masked; clear has priority over capture.
module clm_tag_check #(
    parameter int N     = 4,
    parameter int TAG_W = 8,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             active,
    input  logic [N-1:0]     vld,
    input  logic [N*TAG_W-1:0] tags,
    output logic             mism,
    output logic [IDX_W-1:0] mism_idx
);
    logic             ref_ok;
    logic [TAG_W-1:0] ref_tag;
    logic [TAG_W-1:0] cand;
    logic             found;
    logic [IDX_W-1:0] first;

    // Pick the reference: the stored tag, or the lowest-index word this cycle.
    always_comb begin
        found = 1'b0;
        first = '0;
        for (int i = 0; i < N; i++) begin
            if (vld[i] && !found) begin
                found = 1'b1;
                first = IDX_W'(i);
            end
        end
        cand = ref_ok ? ref_tag : tags[first*TAG_W +: TAG_W];
    end

    // Report the lowest-index word that disagrees with the reference.
    always_comb begin
        mism     = 1'b0;
        mism_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vld[i] && tags[i*TAG_W +: TAG_W] != cand && !mism) begin
                mism     = 1'b1;
                mism_idx = IDX_W'(i);
            end
        end
    end

    // Hold the reference for the rest of the event.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ref_ok  <= 1'b0;
            ref_tag <= '0;
        end else if (active && found && !ref_ok) begin
            ref_ok  <= 1'b1;
            ref_tag <= cand;
        end
    end

    a_r7_ref_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_ok && !clear) |=> (ref_tag == $past(ref_tag)));
endmodule

// File: rtl/clm_word_count.sv
// Counts the designated board's words per event, saturating at two.
// Assumes: vld is that board's masked strobe.
module clm_word_count (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic active,
    input  logic vld,
    output logic over,
    output logic exact
);
    logic [1:0] cnt;
    logic [1:0] cnt_now;

    // Count including the word arriving this cycle.
    always_comb begin
        cnt_now = (active && vld && cnt != 2'd2) ? cnt + 2'd1 : cnt;
        over    = active && vld && cnt != 2'd0;
        exact   = (cnt_now == 2'd1);
    end

    // Register the running count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else                 cnt <= cnt_now;
    end

    a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != 2'd3);
endmodule

// File: rtl/clm_timeout.sv
// Counts collection cycles and signals the last allowed one.
// Assumes: active stays high only while collection is open.
module clm_timeout #(
    parameter int LIMIT = 24000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic active,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    // Flag the final cycle of the window.
    always_comb expired = active && (cnt == CW'(LIMIT - 1));

    // Advance while collecting, saturating at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                      cnt <= '0;
        else if (active && cnt != CW'(LIMIT - 1)) cnt <= cnt + 1'b1;
    end

    a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT - 1));
endmodule

// File: rtl/l2_collect_mon.sv
// Collection completion monitor: decides completion or error per event.
// Assumes: one event open at a time; start_load restarts unconditionally.
module l2_collect_mon #(
    parameter int N_BOARDS    = 4,
    parameter int TAG_W       = 8,
    parameter int TIMEOUT_CYC = 24000,
    parameter int SINGLE_IDX  = 0,
    localparam int IDX_W = (N_BOARDS > 1) ? $clog2(N_BOARDS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_load,
    input  logic [N_BOARDS-1:0]       enable_mask,
    input  logic [N_BOARDS-1:0]       done_in,
    input  logic [N_BOARDS-1:0]       word_vld,
    input  logic [N_BOARDS*TAG_W-1:0] word_tag,
    output logic                      collect_done,
    output logic                      err_flag,
    output logic [IDX_W+2:0]          err_cause,
    output logic                      resync_req
);
    import clm_pkg::*;

    phase_t               phase;
    logic [N_BOARDS-1:0]  vld_m;
    logic                 all_done, in_coll;
    logic                 mism, over, exact, expired;
    logic [IDX_W-1:0]     mism_idx, late_idx;
    logic                 tag_err, cnt_err, to_err, any_err;
    logic [IDX_W-1:0]     err_idx;

    // Mask inputs and find the lowest enabled board not yet done.
    always_comb begin
        vld_m    = word_vld & enable_mask;
        all_done = &(done_in | ~enable_mask);
        in_coll  = (phase == PH_COLLECT) && !start_load;
        late_idx = '0;
        for (int i = N_BOARDS - 1; i >= 0; i--)
            if (enable_mask[i] && !done_in[i]) late_idx = IDX_W'(i);
    end

    clm_tag_check #(.N(N_BOARDS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tag (
        .clk(clk), .rst_n(rst_n), .clear(start_load), .active(in_coll),
        .vld(vld_m), .tags(word_tag), .mism(mism), .mism_idx(mism_idx));

    clm_word_count u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(start_load), .active(in_coll),
        .vld(vld_m[SINGLE_IDX]), .over(over), .exact(exact));

    clm_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk(clk), .rst_n(rst_n), .clear(start_load), .active(in_coll),
        .expired(expired));

    // Combine causes and choose the reported board by priority.
    always_comb begin
        tag_err = in_coll && mism;
        cnt_err = in_coll && enable_mask[SINGLE_IDX] && (over || (all_done && !exact));
        to_err  = in_coll && expired && !all_done;
        any_err = tag_err || cnt_err || to_err;
        if (tag_err)      err_idx = mism_idx;
        else if (cnt_err) err_idx = IDX_W'(SINGLE_IDX);
        else              err_idx = late_idx;
    end

    // Event phase and outcome registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase        <= PH_IDLE;
            collect_done <= 1'b0;
            err_flag     <= 1'b0;
            err_cause    <= '0;
            resync_req   <= 1'b0;
        end else if (start_load) begin
            phase        <= PH_COLLECT;
            collect_done <= 1'b0;
            err_flag     <= 1'b0;
            err_cause    <= '0;
            resync_req   <= 1'b0;
        end else begin
            collect_done <= 1'b0;
            resync_req   <= 1'b0;
            if (in_coll && any_err) begin
                phase      <= PH_CLOSED;
                err_flag   <= 1'b1;
                resync_req <= 1'b1;
                err_cause  <= {err_idx, tag_err, cnt_err, to_err};
            end else if (in_coll && all_done) begin
                phase        <= PH_CLOSED;
                collect_done <= 1'b1;
            end
        end
    end

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(collect_done && err_flag));
    a_r8_resync_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> resync_req);
    a_r8_resync_single: assert property (@(posedge clk) disable iff (!rst_n)
        resync_req |=> !resync_req);
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        collect_done |=> !collect_done);
    a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_load |=> (!err_flag && !collect_done && !resync_req));
    a_r11_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (err_cause[CAUSE_FLAGS-1:0] != '0));
endmodule

// File: tb/sim_l2_collect_mon.sv
module sim_l2_collect_mon;
    localparam int N = 4, TW = 8, TMO = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_load = 1'b0;
    logic [N-1:0]  enable_mask = '0, done_in = '0, word_vld = '0;
    logic [N*TW-1:0] word_tag = '0;
    logic          collect_done, err_flag, resync_req;
    logic [4:0]    err_cause;
    int            n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    l2_collect_mon #(.N_BOARDS(N), .TAG_W(TW), .TIMEOUT_CYC(TMO), .SINGLE_IDX(0)) u0 (
        .clk(clk), .rst_n(rst_n), .start_load(start_load), .enable_mask(enable_mask),
        .done_in(done_in), .word_vld(word_vld), .word_tag(word_tag),
        .collect_done(collect_done), .err_flag(err_flag), .err_cause(err_cause),
        .resync_req(resync_req));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] cause(input int idx, input logic [2:0] bits);
        return {idx[1:0], bits};
    endfunction

    task automatic start_evt(input logic [N-1:0] m);
        @(negedge clk);
        enable_mask = m; done_in = '0; word_vld = '0; start_load = 1'b1;
        @(negedge clk);
        start_load = 1'b0;
    endtask

    task automatic words(input logic [N-1:0] v, input logic [N*TW-1:0] t);
        word_vld = v; word_tag = t;
        @(negedge clk);
        word_vld = '0;
    endtask

    task automatic set_done(input logic [N-1:0] d);
        done_in = d;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 reset done", collect_done, 0);
        check("R1 reset err", err_flag, 0);
        check("R1 reset cause", err_cause, 0);
        check("R1 reset resync", resync_req, 0);
    endtask

    task automatic t_normal;
        start_evt(4'hF);
        words(4'b0001, {8'd0, 8'd0, 8'd0, 8'd5});
        words(4'b1110, {8'd5, 8'd5, 8'd5, 8'd0});
        set_done(4'hF);
        check("R2 complete", collect_done, 1);
        check("R9 no err", err_flag, 0);
        @(negedge clk);
        check("R2 single pulse", collect_done, 0);
    endtask

    task automatic t_mask;
        start_evt(4'b1011);
        words(4'b0001, {8'd0, 8'd0, 8'd0, 8'd3});
        words(4'b0100, {8'd0, 8'd9, 8'd0, 8'd0});
        words(4'b1010, {8'd3, 8'd0, 8'd3, 8'd0});
        set_done(4'b1011);
        check("R3 masked board ignored", collect_done, 1);
        check("R3 masked tag ignored", err_flag, 0);
        start_evt(4'b1110);
        words(4'b1110, {8'd2, 8'd2, 8'd2, 8'd0});
        set_done(4'b1110);
        check("R3 designated masked", collect_done, 1);
    endtask

    task automatic t_timeout;
        start_evt(4'hF);
        words(4'b0001, {8'd0, 8'd0, 8'd0, 8'd1});
        done_in = 4'b1101;
        repeat (18) @(negedge clk);
        check("R4 before window end", err_flag, 0);
        @(negedge clk);
        check("R4 timeout err", err_flag, 1);
        check("R4 timeout cause", err_cause, cause(1, 3'b001));
        check("R8 resync pulse", resync_req, 1);
        @(negedge clk);
        check("R8 resync drops", resync_req, 0);
        check("R8 err held", err_flag, 1);
        start_evt(4'hF);
        check("R1 start clears err", err_flag, 0);
        check("R1 start clears cause", err_cause, 0);
    endtask

    task automatic t_double;
        start_evt(4'hF);
        words(4'b0001, {8'd0, 8'd0, 8'd0, 8'd4});
        words(4'b0001, {8'd0, 8'd0, 8'd0, 8'd4});
        check("R5 second word err", err_flag, 1);
        check("R5 cause", err_cause, cause(0, 3'b010));
    endtask

    task automatic t_zero;
        start_evt(4'hF);
        words(4'b1110, {8'd5, 8'd5, 8'd5, 8'd0});
        set_done(4'hF);
        check("R6 no word err", err_flag, 1);
        check("R6 cause", err_cause, cause(0, 3'b010));
        check("R6 no complete", collect_done, 0);
    endtask

    task automatic t_tag;
        start_evt(4'hF);
        words(4'b0010, {8'd0, 8'd0, 8'd7, 8'd0});
        words(4'b0001, {8'd0, 8'd0, 8'd0, 8'd7});
        check("R7 matching tags ok", err_flag, 0);
        words(4'b1000, {8'd9, 8'd0, 8'd0, 8'd0});
        check("R7 mismatch err", err_flag, 1);
        check("R7 cause", err_cause, cause(3, 3'b100));
        start_evt(4'hF);
        words(4'b1100, {8'd6, 8'd4, 8'd0, 8'd0});
        check("R7 same-cycle ref lowest", err_cause, cause(3, 3'b100));
    endtask

    task automatic t_priority;
        start_evt(4'hF);
        words(4'b0001, {8'd0, 8'd0, 8'd0, 8'd1});
        words(4'b0011, {8'd0, 8'd0, 8'd2, 8'd1});
        check("R10 both causes idx tag", err_cause, cause(1, 3'b110));
    endtask

    task automatic t_excl;
        start_evt(4'hF);
        words(4'b0001, {8'd0, 8'd0, 8'd0, 8'd8});
        set_done(4'hF);
        check("R9 complete", collect_done, 1);
        done_in = 4'h0;
        repeat (TMO + 5) @(negedge clk);
        check("R9 no later err", err_flag, 0);
        check("R9 no later done", collect_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_mask();
        t_timeout();
        t_double();
        t_zero();
        t_tag();
        t_priority();
        t_excl();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule